// File: doc/BRIEF.md
# Saturating Volume Envelope

This block produces the 4-bit loudness value for one sound channel. A trigger
loads a starting level. Slow envelope ticks then walk that level up or down by
one unit at a time, until it hits silence or full scale. The walk rate is set by
a 3-bit pace value, which is the number of accepted ticks between steps. The
direction bit selects a rising or a falling ramp. The output feeds the amplitude
input of a tone or noise generator.

The tick strobe and the register decoding live outside the block. Pace and
direction are read live on every tick. The starting level is read only at a
trigger. Once the ramp reaches either end of the range, the block stops and
ignores all further ticks until the next trigger. Ticks are also ignored while
the owning channel reports itself disabled.

The control is a three-state machine:
- ENV_OFF: never armed, or armed with pace 0.
- ENV_RUN: stepping.
- ENV_HALT: stopped at a limit.

Its transitions are:
- ARM: any state goes to ENV_RUN on a trigger with a non-zero pace.
- PARK: any state goes to ENV_OFF on a trigger with pace 0.
- LIMIT: ENV_RUN goes to ENV_HALT when a step lands on 0 or on the maximum.

Top module: `vol_env_top`

## Requirements
- R1: A synchronous active-high reset drives the volume to 0 and leaves the envelope unarmed, so that ticks after reset do not change the volume.
- R2: A trigger loads `init_vol_i` into the volume. The loaded value is visible one clock after the trigger edge.
- R3: A trigger taken while pace is 0 leaves the envelope unarmed. While pace reads 0, accepted ticks never change the volume.
- R4: While armed, each accepted tick adds one to a step count. When the count plus one reaches or exceeds the live pace, the volume steps and the count returns to 0. With a steady pace P, this gives one step every P accepted ticks.
- R5: A step raises the volume by one when `dir_up_i` is 1 and lowers it by one when `dir_up_i` is 0.
- R6: The volume saturates at 0 and at 15 and never wraps from one end to the other.
- R7: When a step leaves the volume at 0 or at 15, the envelope halts. Later ticks do not change the volume, even after the direction is reversed, until a new trigger.
- R8: A tick taken while `chan_en_i` is 0 changes neither the volume nor the step count.
- R9: A trigger wins over a tick in the same cycle and clears any partial step count, so that a full pace of ticks is needed before the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | One-cycle trigger strobe |
| init_vol_i | input | 4 | Starting volume, loaded on trigger |
| dir_up_i | input | 1 | Ramp direction: 1 rising, 0 falling |
| pace_i | input | 3 | Accepted ticks per step; 0 disables stepping |
| chan_en_i | input | 1 | Owning channel enabled |
| tick_i | input | 1 | One-cycle envelope tick strobe |
| vol_o | output | 4 | Current volume |

## Verification
The properties assume the following about the inputs:
- Every input is a clean synchronous level, sampled once per edge.
- Reset is asserted at the first edge.
- A trigger and a tick may coincide.

The properties make no assumption about the tick rate, so the stimulus issues ticks far faster than any real envelope clock would. The random stimulus changes pace and direction in the middle of a count, drops the channel enable for stretches, and inserts occasional resets. Every combination therefore remains legal input. Directed sequences add the following cases:
- a ramp that reaches a limit and is then reversed;
- a trigger at pace 0;
- a trigger that lands on a tick.

// File: rtl/env_pkg.sv
package env_pkg;

    typedef enum logic [1:0] {
        ENV_OFF  = 2'd0,
        ENV_RUN  = 2'd1,
        ENV_HALT = 2'd2
    } env_state_e;

endpackage

// File: rtl/env_pace_cnt.sv
// Counts accepted ticks and flags the tick on which a volume step is due.
module env_pace_cnt #(
    parameter int PACE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              adv_i,
    input  logic [PACE_W-1:0] pace_i,
    output logic              due_o
);
    localparam int CNT_W = PACE_W + 1;

    logic [PACE_W-1:0] cnt_q;
    logic [CNT_W-1:0]  inc;
    logic              pace_nz;

    always_comb begin
        inc     = CNT_W'(cnt_q) + CNT_W'(1);
        pace_nz = (pace_i != '0);
        due_o   = adv_i && pace_nz && (inc >= CNT_W'(pace_i));
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (adv_i && pace_nz) begin
            if (due_o) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= inc[PACE_W-1:0];
            end
        end
    end

endmodule

// File: rtl/env_vol_sat.sv
// One saturating step of the volume and detection of the range ends.
module env_vol_sat #(
    parameter int VOL_W = 4
) (
    input  logic [VOL_W-1:0] vol_i,
    input  logic             up_i,
    output logic [VOL_W-1:0] vol_o,
    output logic             at_end_o
);
    localparam logic [VOL_W-1:0] VMAX = {VOL_W{1'b1}};

    always_comb begin
        if (up_i) begin
            vol_o = (vol_i == VMAX) ? VMAX : vol_i + VOL_W'(1);
        end else begin
            vol_o = (vol_i == '0) ? '0 : vol_i - VOL_W'(1);
        end
        at_end_o = (vol_o == '0) || (vol_o == VMAX);
    end

endmodule

// File: rtl/vol_env_top.sv
module vol_env_top #(
    parameter int VOL_W  = 4,
    parameter int PACE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [VOL_W-1:0]  init_vol_i,
    input  logic              dir_up_i,
    input  logic [PACE_W-1:0] pace_i,
    input  logic              chan_en_i,
    input  logic              tick_i,
    output logic [VOL_W-1:0]  vol_o
);
    import env_pkg::*;

    env_state_e       state_q, state_d;
    logic             accept;
    logic             due;
    logic [VOL_W-1:0] vol_q, vol_step;
    logic             step_end;
    logic             run;

    assign run    = (state_q == ENV_RUN);
    assign accept = run && chan_en_i && tick_i && !trig_i;

    env_pace_cnt #(.PACE_W(PACE_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear_i (trig_i),
        .adv_i   (accept),
        .pace_i  (pace_i),
        .due_o   (due)
    );

    env_vol_sat #(.VOL_W(VOL_W)) u_sat (
        .vol_i    (vol_q),
        .up_i     (dir_up_i),
        .vol_o    (vol_step),
        .at_end_o (step_end)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (trig_i) begin
            state_d = (pace_i != '0) ? ENV_RUN : ENV_OFF;    // ARM / PARK
        end else begin
            unique case (state_q)
                ENV_OFF:  state_d = ENV_OFF;
                ENV_RUN:  state_d = (due && step_end) ? ENV_HALT : ENV_RUN; // LIMIT
                ENV_HALT: state_d = ENV_HALT;
                default:  state_d = ENV_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENV_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            vol_q <= '0;
        end else if (trig_i) begin
            vol_q <= init_vol_i;
        end else if (due) begin
            vol_q <= vol_step;
        end
    end

    assign vol_o = vol_q;

endmodule

// File: rtl/vol_env_chk.sv
module vol_env_chk #(
    parameter int VOL_W  = 4,
    parameter int PACE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              trig_i,
    input logic [VOL_W-1:0]  init_vol_i,
    input logic              dir_up_i,
    input logic [PACE_W-1:0] pace_i,
    input logic              chan_en_i,
    input logic              tick_i,
    input logic [VOL_W-1:0]  vol_o,
    input logic              run
);
    localparam logic [VOL_W-1:0] VMAX = {VOL_W{1'b1}};

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (vol_o == '0) && !run);

    a_r2_trigger_loads: assert property (@(posedge clk) disable iff (rst)
        trig_i |=> vol_o == $past(init_vol_i));

    a_r3_pace_zero_holds: assert property (@(posedge clk) disable iff (rst)
        (!trig_i && pace_i == '0) |=> $stable(vol_o));

    a_r5_rises_when_up: assert property (@(posedge clk) disable iff (rst)
        (!trig_i && dir_up_i) |=> vol_o >= $past(vol_o));

    a_r5_falls_when_down: assert property (@(posedge clk) disable iff (rst)
        (!trig_i && !dir_up_i) |=> vol_o <= $past(vol_o));

    a_r6_no_wrap_top: assert property (@(posedge clk) disable iff (rst)
        (!trig_i && vol_o == VMAX) |=> vol_o != '0);

    a_r6_no_wrap_bottom: assert property (@(posedge clk) disable iff (rst)
        (!trig_i && vol_o == '0) |=> vol_o != VMAX);

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!trig_i && !run) |=> !run && $stable(vol_o));

    a_r8_channel_off_holds: assert property (@(posedge clk) disable iff (rst)
        (!trig_i && !chan_en_i) |=> $stable(vol_o));

endmodule

bind vol_env_top vol_env_chk #(.VOL_W(VOL_W), .PACE_W(PACE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trig_i     (trig_i),
    .init_vol_i (init_vol_i),
    .dir_up_i   (dir_up_i),
    .pace_i     (pace_i),
    .chan_en_i  (chan_en_i),
    .tick_i     (tick_i),
    .vol_o      (vol_o),
    .run        (run)
);

// File: tb/sim_vol_env_top.sv
`timescale 1ns/1ps
module sim_vol_env_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig_i = 1'b0;
    logic [3:0] init_vol_i = 4'd0;
    logic       dir_up_i = 1'b0;
    logic [2:0] pace_i = 3'd0;
    logic       chan_en_i = 1'b0;
    logic       tick_i = 1'b0;
    logic [3:0] vol_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0] m_vol = 4'd0;
    bit         m_run = 1'b0;
    int         m_cnt = 0;
    string      tag = "R1";

    always #2.5 clk = ~clk;

    vol_env_top u0 (
        .clk(clk), .rst(rst), .trig_i(trig_i), .init_vol_i(init_vol_i),
        .dir_up_i(dir_up_i), .pace_i(pace_i), .chan_en_i(chan_en_i),
        .tick_i(tick_i), .vol_o(vol_o)
    );

    function automatic logic [3:0] sat_step(logic [3:0] v, bit up);
        if (up) return (v == 4'd15) ? 4'd15 : v + 4'd1;
        return (v == 4'd0) ? 4'd0 : v - 4'd1;
    endfunction

    // Predict the volume after the coming edge from the current inputs.
    task automatic model();
        if (rst) begin
            m_vol = 0; m_run = 0; m_cnt = 0; tag = "R1";
        end else if (trig_i) begin
            m_vol = init_vol_i; m_cnt = 0; m_run = (pace_i != 0);
            tag = tick_i ? "R9" : (pace_i == 0 ? "R3" : "R2");
        end else if (tick_i) begin
            if (!chan_en_i) tag = "R8";
            else if (!m_run) tag = "R7";
            else if (pace_i == 0) tag = "R3";
            else if (m_cnt + 1 >= int'(pace_i)) begin
                logic [3:0] nv;
                nv = sat_step(m_vol, dir_up_i);
                tag = (nv == m_vol) ? "R6" : "R5";
                m_vol = nv; m_cnt = 0;
                if (nv == 0 || nv == 15) m_run = 0;
            end else begin
                m_cnt++; tag = "R4";
            end
        end
    endtask

    task automatic check();
        n_chk++;
        if (vol_o !== m_vol) begin
            n_bad++;
            $display("FAIL %s: vol_o=%0d expected %0d at %0t", tag, vol_o, m_vol, $time);
        end
    endtask

    // Drive one cycle of inputs, predict, then compare after the edge.
    task automatic cyc(bit r, bit t, logic [3:0] iv, bit d, logic [2:0] p, bit c, bit k);
        rst = r; trig_i = t; init_vol_i = iv; dir_up_i = d; pace_i = p;
        chan_en_i = c; tick_i = k;
        model();
        @(negedge clk);
        check();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        cyc(1, 0, 0, 0, 0, 0, 0);                      // R1 reset
        cyc(0, 0, 0, 1, 1, 1, 1);                      // R1 ticks after reset: no change
        cyc(0, 0, 0, 1, 1, 1, 1);
        // R3 trigger at pace 0
        cyc(0, 1, 4'd7, 1, 0, 1, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 4'd0, 1, 0, 1, 1);
        // R2/R5/R6/R7 rising ramp to top, then reversed
        cyc(0, 1, 4'd12, 1, 1, 1, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, 4'd0, 1, 1, 1, 1);
        for (int i = 0; i < 3; i++) cyc(0, 0, 4'd0, 0, 1, 1, 1);
        // R4 falling ramp, pace 3
        cyc(0, 1, 4'd9, 0, 3, 1, 0);
        for (int i = 0; i < 9; i++) cyc(0, 0, 4'd0, 0, 3, 1, 1);
        // R8 channel off: no count progress
        cyc(0, 0, 4'd0, 0, 3, 1, 1);
        for (int i = 0; i < 5; i++) cyc(0, 0, 4'd0, 0, 3, 0, 1);
        cyc(0, 0, 4'd0, 0, 3, 1, 1);
        cyc(0, 0, 4'd0, 0, 3, 1, 1);
        // R9 trigger with tick, mid-count
        cyc(0, 1, 4'd5, 1, 2, 1, 0);
        cyc(0, 0, 4'd0, 1, 2, 1, 1);
        cyc(0, 1, 4'd5, 1, 2, 1, 1);
        cyc(0, 0, 4'd0, 1, 2, 1, 1);
        cyc(0, 0, 4'd0, 1, 2, 1, 1);
        // R6 falling ramp from 1 hits 0
        cyc(0, 1, 4'd1, 0, 1, 1, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 4'd0, 0, 1, 1, 1);
        // constrained random
        begin
            bit d = 1; logic [2:0] p = 3'd2; bit c = 1;
            for (int i = 0; i < 4000; i++) begin
                bit r, t, k;
                r = ($urandom_range(499) == 0);
                t = ($urandom_range(39) == 0);
                k = ($urandom_range(2) == 0);
                if ($urandom_range(19) == 0) d = ~d;
                if ($urandom_range(49) == 0) p = 3'($urandom_range(7));
                if ($urandom_range(29) == 0) c = ~c;
                cyc(r, t, 4'($urandom_range(15)), d, p, c, k);
            end
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule